// File: doc/BRIEF.md
# UART Bit-Clock Rate Generator

This block derives the serial bit-clock enable for a UART from the core's instruction-cycle tick, which runs at one quarter of the main clock. The tick first passes through a prescaler. Software chooses its division with a two-bit primary select. One code of that select hands the choice to a secondary timer source, which has its own two-bit encoding. The prescaled tick then drives a reload timer with an 8-bit compare value. On every compare match the timer reloads and flips its output, so one full output cycle spans two compare periods.

A final divider counts whole timer output cycles. In asynchronous mode it divides by 16 or 64, chosen by the rate bit. In synchronous mode it divides by 2 and ignores the rate bit. When the terminal count is reached, the block emits a single-cycle enable.

Configuration inputs are captured in a shadow register. The capture happens at a compare match, or at any time while the generator is stopped or misconfigured, so a running period is never cut short. A prohibited secondary code stops the generator and raises a flag.

Top module: `uart_baud_gen`

## Requirements
- R1: While running with a legal configuration, `bit_en` pulses once every P ticks, where P = Npre * (cmp + 1) * 2 * Dfin. A tick is a clock cycle with `tick_en` high, and cycles without a tick do not advance any counter. The pulse is seen in the cycle after the edge that consumed the P-th tick counted from the start of the run.
- R2: The primary select `pre_sel` gives Npre as follows: 0 gives 1, 1 gives 16, 2 gives 32, and 3 uses the secondary source.
- R3: When `pre_sel` = 3, the secondary select `sec_sel` gives Npre as follows: 0 gives 1, 1 gives 4, 2 gives 32. Code 3 is prohibited.
- R4: With `sync_mode` = 0, Dfin is 16 when `rate_hi` = 0 and 64 when `rate_hi` = 1.
- R5: With `sync_mode` = 1, Dfin is 2 whatever the value of `rate_hi`.
- R6: `cfg_bad` is high exactly while `pre_sel` = 3 and `sec_sel` = 3. While it is high, no `bit_en` pulse occurs and all counters are held at zero. With `pre_sel` other than 3, `sec_sel` = 3 is harmless.
- R7: A change to `cmp_val`, the selects or the mode bits during a run is applied at the next compare match. Every bit period that starts after that match uses the new values in full.
- R8: While `run` is low, all counters are cleared and `bit_en` stays low. A new run counts its first period from zero.
- R9: `bit_en` is never high in two consecutive cycles.
- R10: After reset, `bit_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Instruction-cycle tick enable |
| pre_sel | input | 2 | Primary prescaler select |
| sec_sel | input | 2 | Secondary source select |
| cmp_val | input | CMP_W | Reload timer compare value |
| rate_hi | input | 1 | Asynchronous rate bit (0: /16, 1: /64) |
| sync_mode | input | 1 | 1 selects synchronous mode (/2) |
| run | input | 1 | Generator enable |
| bit_en | output | 1 | One-cycle bit-clock enable |
| cfg_bad | output | 1 | Prohibited secondary code selected |

## Verification
The assertions rely on the shortest legal bit period being at least four ticks, which makes back-to-back pulses impossible. They also rely on `run` and the selects being ordinary synchronous levels. Random configurations are drawn only from legal codes, with the compare value and prescaler trimmed so that each period stays short. The prohibited code and mid-run compare changes are applied as directed cases. Tick density is randomised between 60 and 100 percent to exercise the gating without stretching the run.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned ASYNC_LO_DIV = 16;
  localparam int unsigned ASYNC_HI_DIV = 64;
  localparam int unsigned SYNC_DIV     = 2;

  typedef struct packed {
    logic [1:0] pre;
    logic [1:0] sec;
    logic       rate_hi;
    logic       sync;
  } sel_t;

  function automatic logic sel_illegal(input logic [1:0] pre, input logic [1:0] sec);
    return (pre == 2'd3) && (sec == 2'd3);
  endfunction

  function automatic int unsigned prescale_div(input logic [1:0] pre, input logic [1:0] sec);
    int unsigned d;
    case (pre)
      2'd0: d = 1;
      2'd1: d = 16;
      2'd2: d = 32;
      default: begin
        case (sec)
          2'd0:    d = 1;
          2'd1:    d = 4;
          2'd2:    d = 32;
          default: d = 1;
        endcase
      end
    endcase
    return d;
  endfunction

  function automatic int unsigned final_div(input logic sync, input logic rate_hi);
    if (sync) return SYNC_DIV;
    return rate_hi ? ASYNC_HI_DIV : ASYNC_LO_DIV;
  endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] div,
  output logic             pre_tick
);
  logic [DIV_W-1:0] cnt;

  assign pre_tick = tick_en && !clr && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (pre_tick) cnt <= '0;
    else if (tick_en) cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pre_tick,
  input  logic [CMP_W-1:0] cmp,
  output logic             match,
  output logic             cyc_done,
  output logic [CMP_W-1:0] tcnt
);
  logic tog;

  assign match    = pre_tick && (tcnt == cmp);
  assign cyc_done = match && tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      tog  <= 1'b0;
    end else if (clr) begin
      tcnt <= '0;
      tog  <= 1'b0;
    end else if (match) begin
      tcnt <= '0;
      tog  <= ~tog;
    end else if (pre_tick) begin
      tcnt <= tcnt + CMP_W'(1);
    end
  end
endmodule

// File: rtl/baud_final_div.sv
module baud_final_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);
  logic [DIV_W-1:0] dcnt;
  logic             term;

  assign term = step && (dcnt >= div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      dcnt  <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term)      dcnt <= '0;
      else if (step) dcnt <= dcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int CMP_W  = 8,
  parameter int PDIV_W = 6,
  parameter int FDIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       pre_sel,
  input  logic [1:0]       sec_sel,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             rate_hi,
  input  logic             sync_mode,
  input  logic             run,
  output logic             bit_en,
  output logic             cfg_bad
);
  sel_t             sel_live, sel_s;
  logic [CMP_W-1:0] cmp_s;
  logic             bad_live, bad_shd, hold, cfg_load;
  logic             pre_tick, tmr_match, cyc_done;
  logic [CMP_W-1:0] tcnt;
  logic [PDIV_W-1:0] pdiv;
  logic [FDIV_W-1:0] fdiv;

  assign sel_live = {pre_sel, sec_sel, rate_hi, sync_mode};
  assign bad_live = sel_illegal(pre_sel, sec_sel);
  assign bad_shd  = sel_illegal(sel_s.pre, sel_s.sec);
  assign hold     = !run || bad_live || bad_shd;
  assign cfg_load = hold || tmr_match;
  assign cfg_bad  = bad_live;

  assign pdiv = PDIV_W'(prescale_div(sel_s.pre, sel_s.sec));
  assign fdiv = FDIV_W'(final_div(sel_s.sync, sel_s.rate_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_s <= '0;
      cmp_s <= '0;
    end else if (cfg_load) begin
      sel_s <= sel_live;
      cmp_s <= cmp_val;
    end
  end

  baud_prescale #(.DIV_W(PDIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(hold), .tick_en(tick_en),
    .div(pdiv), .pre_tick(pre_tick)
  );

  baud_reload_timer #(.CMP_W(CMP_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(hold), .pre_tick(pre_tick),
    .cmp(cmp_s), .match(tmr_match), .cyc_done(cyc_done), .tcnt(tcnt)
  );

  baud_final_div #(.DIV_W(FDIV_W)) u_fin (
    .clk(clk), .rst_n(rst_n), .clr(hold), .step(cyc_done),
    .div(fdiv), .pulse(bit_en)
  );
endmodule

module baud_gen_chk #(
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cfg_bad,
  input logic             bit_en,
  input logic             tmr_match,
  input logic             cfg_load,
  input logic [CMP_W-1:0] cmp_s,
  input logic [CMP_W-1:0] tcnt
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en);
  // R8
  run_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bit_en);
  // R8
  run_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tcnt == '0));
  // R6
  bad_cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> (!bit_en && tcnt == '0));
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cmp_s));
  // R1
  pulse_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> $past(tmr_match));
endmodule

bind uart_baud_gen baud_gen_chk #(.CMP_W(CMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_bad(cfg_bad), .bit_en(bit_en),
  .tmr_match(tmr_match), .cfg_load(cfg_load), .cmp_s(cmp_s), .tcnt(tcnt)
);

// File: tb/test_uart_baud_gen.sv
`timescale 1ns/1ps
module test_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, run, rate_hi, sync_mode;
  logic [1:0] pre_sel, sec_sel;
  logic [7:0] cmp_val;
  logic       bit_en, cfg_bad;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_baud_gen i_uart_baud_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pre_sel(pre_sel),
    .sec_sel(sec_sel), .cmp_val(cmp_val), .rate_hi(rate_hi),
    .sync_mode(sync_mode), .run(run), .bit_en(bit_en), .cfg_bad(cfg_bad)
  );

  function automatic int exp_pre(input int p, input int s);
    int tbl_p [4] = '{1, 16, 32, 0};
    int tbl_s [4] = '{1, 4, 32, 0};
    return (p == 3) ? tbl_s[s] : tbl_p[p];
  endfunction

  function automatic int exp_fin(input int sy, input int hi);
    if (sy != 0) return 2;
    return 16 << (2 * hi);
  endfunction

  function automatic int exp_period(input int p, input int s, input int c,
                                    input int hi, input int sy);
    return exp_pre(p, s) * (c + 1) * 2 * exp_fin(sy, hi);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input int p, input int s, input int c, input int hi, input int sy);
    @(negedge clk);
    run = 1'b0; tick_en = 1'b0;
    pre_sel = 2'(p); sec_sel = 2'(s); cmp_val = 8'(c);
    rate_hi = hi[0]; sync_mode = sy[0];
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic seg(input int cycles, input int period, input int dens, input string req);
    int  n = 0;
    bit  pend = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (pend || bit_en) check(bit_en === pend, req, int'(bit_en), int'(pend));
      tick_en = ($urandom_range(99) < dens);
      if (tick_en) begin
        n++;
        pend = (n % period == 0);
      end else pend = 1'b0;
    end
    @(negedge clk);
    if (pend || bit_en) check(bit_en === pend, req, int'(bit_en), int'(pend));
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p, s, c, hi, sy, per, dens, w, cnt;
    void'($urandom(32'h5eed_b0d5));
    rst_n = 1'b0; tick_en = 1'b0; run = 1'b0; rate_hi = 1'b0; sync_mode = 1'b0;
    pre_sel = 2'd0; sec_sel = 2'd0; cmp_val = 8'd0;
    repeat (3) @(negedge clk);
    check(bit_en === 1'b0, "R10 reset bit_en", int'(bit_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_en === 1'b0, "R10 after reset", int'(bit_en), 0);

    // R1 fastest async and slowest compare
    restart(0, 0, 0, 0, 0); seg(200, exp_period(0, 0, 0, 0, 0), 100, "R1 cmp=0");
    restart(0, 0, 255, 0, 0); seg(8200, exp_period(0, 0, 255, 0, 0), 100, "R1 cmp=255");
    // R2 primary prescaler codes
    restart(1, 0, 0, 0, 0); seg(1100, exp_period(1, 0, 0, 0, 0), 100, "R2 pre=1");
    restart(2, 3, 0, 0, 1); seg(300, exp_period(2, 0, 0, 0, 1), 100, "R2 pre=2");
    // R3 secondary source codes
    restart(3, 1, 0, 0, 0); seg(300, exp_period(3, 1, 0, 0, 0), 100, "R3 sec=1");
    restart(3, 2, 0, 0, 1); seg(300, exp_period(3, 2, 0, 0, 1), 100, "R3 sec=2");
    restart(3, 0, 2, 0, 1); seg(100, exp_period(3, 0, 2, 0, 1), 90, "R3 sec=0");
    // R4 async rate bit
    restart(0, 0, 1, 1, 0); seg(600, exp_period(0, 0, 1, 1, 0), 100, "R4 rate_hi");
    // R5 sync ignores rate bit
    restart(0, 0, 1, 1, 1); seg(100, 8, 100, "R5 sync rate_hi=1");
    restart(0, 0, 1, 0, 1); seg(100, 8, 80, "R5 sync rate_hi=0");

    // R6 prohibited secondary code
    restart(3, 3, 0, 0, 1);
    @(negedge clk);
    check(cfg_bad === 1'b1, "R6 flag", int'(cfg_bad), 1);
    seg(300, 1 << 30, 100, "R6 no pulses");
    restart(0, 3, 0, 0, 1);
    @(negedge clk);
    check(cfg_bad === 1'b0, "R6 sec unused", int'(cfg_bad), 0);
    seg(100, 4, 100, "R6 recovery");

    // R8 stop clears a partial period
    restart(0, 0, 1, 0, 0); seg(40, 64, 100, "R8 partial");
    @(negedge clk); run = 1'b0; tick_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(bit_en === 1'b0, "R8 stopped", int'(bit_en), 0);
    end
    tick_en = 1'b0; run = 1'b1;
    seg(200, 64, 100, "R8 restart from zero");

    // R7 compare change mid-run
    restart(0, 0, 3, 0, 0);
    tick_en = 1'b1;
    repeat (50) @(negedge clk);
    cmp_val = 8'd1;
    w = 0;
    while (!bit_en && w < 1000) begin @(negedge clk); w++; end
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!bit_en && cnt < 1000);
    check(cnt == 64, "R7 new period", cnt, 64);
    tick_en = 1'b0;

    // R1 R2 R3 R4 R5 random legal configurations with gated ticks
    for (int t = 0; t < 12; t++) begin
      p = $urandom_range(3); s = $urandom_range(2); c = $urandom_range(7);
      hi = $urandom_range(1); sy = $urandom_range(1);
      per = exp_period(p, s, c, hi, sy);
      if (per > 1500) begin c = 0; per = exp_period(p, s, c, hi, sy); end
      if (per > 1500) begin p = 0; per = exp_period(p, s, c, hi, sy); end
      dens = 60 + $urandom_range(40);
      restart(p, s, c, hi, sy);
      seg((2 * per * 100) / dens + 40, per, dens, "R1 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule